// File: doc/BRIEF.md
# Banked Vector-Load Conflict Scheduler

This block serves 128-bit vector loads issued by a group of 32 lanes against a scratchpad built from 32 banks of 32-bit words. Each active lane gives a byte address aligned to 16 bytes. Such an address selects one aligned group of four adjacent banks and one row within them. When several lanes land in the same bank group at different addresses, the scheduler spreads their accesses over time. Within each four-cycle window, up to four colliding lanes are given rotated word orders, so every bank of the group serves a different lane in every cycle. Lanes that present an identical address share one access, and the data is copied to all of them.

A request is the whole lane vector: one address per lane plus a mask of active lanes. Requests enter a short queue and are executed one transaction at a time. During a transaction the block drives per-bank read enables and row numbers to the bank array. It takes back the read data one cycle later and steers each word into the correct slot of the owning lane. When every word has landed, all 32 lane results are presented together with the mask. A request whose active lanes include a misaligned address is dropped and reported on an error pulse.

Top module: `vload_sched`

## Requirements
- R1: After reset, req_ready is high, and rsp_valid, err_valid and every bank_rd_en bit are low.
- R2: For an active lane with byte address a, the bank group is g = a[6:4] and the row is a[15:7]. Word k (0..3) of that lane's result is read from bank 4*g+k at that row. It is returned on rsp_data bits [(lane*4+k)*32 +: 32], with word 0 in the lowest slot.
- R3: Within a bank group, each distinct address gets a rank r, in ascending order of the lowest lane that carries it. Rank r is served in run window r/4, which covers run cycles 4*(r/4) to 4*(r/4)+3. In the cycle with offset c inside that window, rank r reads word ((r mod 4) + c) mod 4.
- R4: A transaction issues reads for 4*ceil(N/4) consecutive cycles, where N is the largest number of distinct active addresses found in any one bank group (at least one window). With 32 distinct addresses in one group, reads are issued for 32 cycles.
- R5: Bank groups are scheduled independently in the same cycles. Four distinct addresses in each of the eight groups take a single window, with all 32 banks enabled in each of its cycles.
- R6: Active lanes with identical addresses cost one read per word. An all-lanes broadcast enables exactly one bank per cycle over 4 cycles, and every lane receives the same four words.
- R7: Inactive lanes are ignored, including their address bits and alignment. Their result words are zero, and rsp_mask equals the request mask.
- R8: rsp_valid is a one-cycle pulse. It comes two cycles after the last cycle with a read enable, and L+3 cycles after the clock edge that accepted the request, where L is the read length from R4.
- R9: No bank is read outside a running transaction. Transactions run one at a time, and their responses come back in acceptance order.
- R10: The queue holds 4 requests. req_ready is low while it is full, and the request is then not taken.
- R11: If any active lane has a nonzero address[3:0], the request issues no bank read and gives no response. Instead, err_valid pulses for one cycle, 2 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can take a request |
| req_mask | input | 32 | Active-lane mask |
| req_addr | input | 512 | Byte address per lane, 16 bits each, lane 0 lowest |
| bank_rd_en | output | 32 | Read enable per bank |
| bank_row | output | 288 | Row per bank, 9 bits each, bank 0 lowest |
| bank_rdata | input | 1024 | Read data per bank, due the cycle after the enable |
| rsp_valid | output | 1 | Results present (one cycle) |
| rsp_mask | output | 32 | Mask of the completed request |
| rsp_data | output | 4096 | Four 32-bit words per lane |
| err_valid | output | 1 | Misaligned request dropped |

## Verification
Counting from the edge that accepts a request:
- The planning cycle comes first.
- Bank reads are due in cycles 2 to L+1.
- The response is due in cycle L+3.
- A misaligned request raises its error in cycle 2.

Each directed task records the read pattern cycle by cycle, sampling 1 ns after every edge. It checks the recorded pattern against those exact cycle offsets, and it checks the distance from the last read to the response. The bank array in the bench answers each read with a word built from bank number and row. This lets every returned word be predicted from the lane address alone.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAN = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } sched_state_e;

  // Word a lane at quad slot `slot` fetches in window cycle `cyc`
  function automatic logic [1:0] word_sel(input logic [1:0] slot, input logic [1:0] cyc);
    return slot + cyc;
  endfunction

  // Quad slot that a bank holding word `word` serves in window cycle `cyc`
  function automatic logic [1:0] slot_for_word(input logic [1:0] word, input logic [1:0] cyc);
    return word - cyc;
  endfunction

endpackage

// File: rtl/vls_fifo.sv
`timescale 1ns/1ps
module vls_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vls_planner.sv
`timescale 1ns/1ps
module vls_planner #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16,
  parameter int GRP_W  = 3,
  parameter int RANK_W = 5,
  localparam int WIN_W = RANK_W - 2
) (
  input  logic [LANES-1:0]             mask,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  output logic [LANES-1:0]             leader,
  output logic [LANES-1:0][RANK_W-1:0] rank,
  output logic [WIN_W-1:0]             last_win,
  output logic                         misaligned
);
  logic [LANES-1:0][RANK_W-1:0] lead_rank;

  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] a);
    return a[4 +: GRP_W];
  endfunction

  // A lane leads when no lower active lane carries the same address
  always_comb begin
    leader = mask;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (j < i && mask[j] && addr[j] == addr[i]) leader[i] = 1'b0;
  end

  // Leader rank: leaders below it in the same bank group
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lead_rank[i] = '0;
      for (int j = 0; j < LANES; j++)
        if (j < i && leader[j] && grp_of(addr[j]) == grp_of(addr[i]))
          lead_rank[i] = lead_rank[i] + RANK_W'(1);
    end
  end

  // Followers inherit the rank of the lowest lane with their address
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rank[i] = lead_rank[i];
      for (int j = LANES - 1; j >= 0; j--)
        if (j < i && mask[j] && addr[j] == addr[i]) rank[i] = lead_rank[j];
    end
  end

  always_comb begin
    last_win   = '0;
    misaligned = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i] && rank[i][RANK_W-1:2] > last_win) last_win = rank[i][RANK_W-1:2];
      if (mask[i] && addr[i][3:0] != 4'd0) misaligned = 1'b1;
    end
  end
endmodule

// File: rtl/vls_issue.sv
`timescale 1ns/1ps
module vls_issue
  import vls_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int GRP_W  = 3,
  parameter int RANK_W = 5,
  parameter int ROW_W  = 9,
  localparam int WIN_W = RANK_W - 2
) (
  input  logic                         active,
  input  logic [WIN_W-1:0]             win,
  input  logic [1:0]                   cyc,
  input  logic [LANES-1:0]             leader,
  input  logic [LANES-1:0][RANK_W-1:0] rank,
  input  logic [LANES-1:0][GRP_W-1:0]  lane_grp,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
  output logic [BANKS-1:0]             rd_en,
  output logic [BANKS-1:0][ROW_W-1:0]  rd_row
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [GRP_W-1:0] BANK_GRP  = GRP_W'(b / 4);
    localparam logic [1:0]       BANK_WORD = 2'(b % 4);
    logic [RANK_W-1:0] want;
    assign want = {win, slot_for_word(BANK_WORD, cyc)};

    always_comb begin
      rd_en[b]  = 1'b0;
      rd_row[b] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (active && leader[i] && lane_grp[i] == BANK_GRP && rank[i] == want) begin
          rd_en[b]  = 1'b1;
          rd_row[b] = lane_row[i];
        end
      end
    end
  end
endmodule

// File: rtl/vls_collect.sv
`timescale 1ns/1ps
module vls_collect
  import vls_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int WORD_W = 32,
  parameter int GRP_W  = 3,
  parameter int RANK_W = 5,
  localparam int WIN_W  = RANK_W - 2,
  localparam int BANK_W = GRP_W + 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               cap_valid,
  input  logic [WIN_W-1:0]                   cap_win,
  input  logic [1:0]                         cap_cyc,
  input  logic [LANES-1:0]                   mask,
  input  logic [LANES-1:0][RANK_W-1:0]       rank,
  input  logic [LANES-1:0][GRP_W-1:0]        lane_grp,
  input  logic [BANKS-1:0][WORD_W-1:0]       rdata,
  output logic [LANES-1:0][3:0][WORD_W-1:0]  result
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]              word;
    logic [BANK_W-1:0]       src;
    logic                    hit;
    logic [3:0][WORD_W-1:0]  slot;

    assign word = word_sel(rank[i][1:0], cap_cyc);
    assign src  = {lane_grp[i], word};
    assign hit  = cap_valid && mask[i] && (rank[i][RANK_W-1:2] == cap_win);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot <= '0;
      else if (clear) slot <= '0;
      else if (hit)   slot[word] <= rdata[src];
    end

    assign result[i] = slot;
  end
endmodule

// File: rtl/vload_sched.sv
`timescale 1ns/1ps
module vload_sched
  import vls_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int QDEPTH = 4,
  localparam int ROW_W = ADDR_W - 2 - $clog2(BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [LANES-1:0]            req_mask,
  input  logic [LANES*ADDR_W-1:0]     req_addr,
  output logic [BANKS-1:0]            bank_rd_en,
  output logic [BANKS*ROW_W-1:0]      bank_row,
  input  logic [BANKS*WORD_W-1:0]     bank_rdata,
  output logic                        rsp_valid,
  output logic [LANES-1:0]            rsp_mask,
  output logic [LANES*4*WORD_W-1:0]   rsp_data,
  output logic                        err_valid
);
  localparam int GRP_W   = $clog2(BANKS / 4);
  localparam int ROW_LSB = 2 + $clog2(BANKS);
  localparam int RANK_W  = $clog2(LANES);
  localparam int WIN_W   = RANK_W - 2;
  localparam int Q_W     = LANES + LANES * ADDR_W;
  localparam int CNT_W   = $clog2(QDEPTH + 1);

  // Queue
  logic             q_push, q_pop, q_full, q_empty;
  logic [Q_W-1:0]   q_dout;
  logic [CNT_W-1:0] q_count;

  sched_state_e state;
  logic         run_active;

  assign q_push    = req_valid && req_ready;
  assign q_pop     = (state == ST_IDLE) && !q_empty;
  assign req_ready = !q_full;

  vls_fifo #(.W(Q_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din({req_mask, req_addr}),
    .pop(q_pop), .dout(q_dout), .full(q_full), .empty(q_empty), .count(q_count)
  );

  // Transaction held while it runs
  logic [LANES-1:0]             txn_mask;
  logic [LANES-1:0][ADDR_W-1:0] txn_addr;
  logic [LANES-1:0][GRP_W-1:0]  lane_grp;
  logic [LANES-1:0][ROW_W-1:0]  lane_row;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_grp[i] = txn_addr[i][4 +: GRP_W];
      lane_row[i] = txn_addr[i][ROW_LSB +: ROW_W];
    end
  end

  // Plan (combinational from the held transaction)
  logic [LANES-1:0]             plan_leader, leader_q;
  logic [LANES-1:0][RANK_W-1:0] plan_rank, rank_q;
  logic [WIN_W-1:0]             plan_last_win, last_win_q;
  logic                         plan_misaligned;

  vls_planner #(.LANES(LANES), .ADDR_W(ADDR_W), .GRP_W(GRP_W), .RANK_W(RANK_W)) u_plan (
    .mask(txn_mask), .addr(txn_addr), .leader(plan_leader), .rank(plan_rank),
    .last_win(plan_last_win), .misaligned(plan_misaligned)
  );

  // Run position
  logic [WIN_W-1:0] t_win, cap_win;
  logic [1:0]       t_cyc, cap_cyc;
  logic             cap_valid;
  logic             run_last;

  assign run_active = (state == ST_RUN);
  assign run_last   = (t_cyc == 2'd3) && (t_win == last_win_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      txn_mask   <= '0;
      txn_addr   <= '0;
      leader_q   <= '0;
      rank_q     <= '0;
      last_win_q <= '0;
      t_win      <= '0;
      t_cyc      <= '0;
      cap_valid  <= 1'b0;
      cap_win    <= '0;
      cap_cyc    <= '0;
      rsp_valid  <= 1'b0;
      rsp_mask   <= '0;
      err_valid  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      err_valid <= 1'b0;
      cap_valid <= run_active;
      cap_win   <= t_win;
      cap_cyc   <= t_cyc;
      case (state)
        ST_IDLE: begin
          if (q_pop) begin
            txn_mask <= q_dout[Q_W-1 -: LANES];
            txn_addr <= q_dout[LANES*ADDR_W-1:0];
            state    <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (plan_misaligned) begin
            err_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            leader_q   <= plan_leader;
            rank_q     <= plan_rank;
            last_win_q <= plan_last_win;
            t_win      <= '0;
            t_cyc      <= '0;
            state      <= ST_RUN;
          end
        end
        ST_RUN: begin
          t_cyc <= t_cyc + 2'd1;
          if (run_last)            state <= ST_TAIL;
          else if (t_cyc == 2'd3)  t_win <= t_win + WIN_W'(1);
        end
        ST_TAIL: begin
          rsp_valid <= 1'b1;
          rsp_mask  <= txn_mask;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Bank request generation
  logic [BANKS-1:0][ROW_W-1:0] row_arr;

  vls_issue #(.LANES(LANES), .BANKS(BANKS), .GRP_W(GRP_W), .RANK_W(RANK_W), .ROW_W(ROW_W)) u_issue (
    .active(run_active), .win(t_win), .cyc(t_cyc), .leader(leader_q), .rank(rank_q),
    .lane_grp(lane_grp), .lane_row(lane_row), .rd_en(bank_rd_en), .rd_row(row_arr)
  );
  assign bank_row = row_arr;

  // Return-data steering
  logic [BANKS-1:0][WORD_W-1:0]      rdata_arr;
  logic [LANES-1:0][3:0][WORD_W-1:0] result;

  assign rdata_arr = bank_rdata;

  vls_collect #(.LANES(LANES), .BANKS(BANKS), .WORD_W(WORD_W), .GRP_W(GRP_W), .RANK_W(RANK_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_PLAN), .cap_valid(cap_valid),
    .cap_win(cap_win), .cap_cyc(cap_cyc), .mask(txn_mask), .rank(rank_q),
    .lane_grp(lane_grp), .rdata(rdata_arr), .result(result)
  );
  assign rsp_data = result;

endmodule

// File: rtl/vload_sched_chk.sv
`timescale 1ns/1ps
module vload_sched_chk #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BANKS-1:0] bank_rd_en,
  input logic             rsp_valid,
  input logic [LANES-1:0] rsp_mask,
  input logic             err_valid,
  input logic             run_active,
  input logic             q_push,
  input logic [CNT_W-1:0] q_count
);
  AST_READ_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd_en != '0) |-> run_active); // R9

  AST_NO_RSP_DURING_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !run_active); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

  AST_RSP_AFTER_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask != '0) |-> ($past(bank_rd_en) == '0 && $past(bank_rd_en, 2) != '0)); // R8

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (bank_rd_en == '0 && !rsp_valid && !run_active)); // R11

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (q_count < CNT_W'(QDEPTH))); // R10
endmodule

bind vload_sched vload_sched_chk #(.LANES(LANES), .BANKS(BANKS), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_rd_en(bank_rd_en), .rsp_valid(rsp_valid),
  .rsp_mask(rsp_mask), .err_valid(err_valid), .run_active(run_active),
  .q_push(q_push), .q_count(q_count)
);

// File: tb/vload_sched_bench.sv
`timescale 1ns/1ps
module vload_sched_bench;
  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 32;
  localparam int ROW_W  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [BANKS-1:0] bank_rd_en;
  logic [BANKS*ROW_W-1:0] bank_row;
  logic [BANKS*WORD_W-1:0] bank_rdata = '0;
  logic rsp_valid;
  logic [LANES-1:0] rsp_mask;
  logic [LANES*4*WORD_W-1:0] rsp_data;
  logic err_valid;

  always #2.5 clk = ~clk;

  vload_sched u_vload_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .bank_rd_en(bank_rd_en),
    .bank_row(bank_row), .bank_rdata(bank_rdata), .rsp_valid(rsp_valid),
    .rsp_mask(rsp_mask), .rsp_data(rsp_data), .err_valid(err_valid)
  );

  // Bank array model: word value built from bank number and row
  function automatic logic [31:0] bank_val(input int b, input logic [ROW_W-1:0] row);
    return {8'(b), 8'h5A, 7'd0, row};
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] a, input int k);
    return bank_val(int'(a[6:4]) * 4 + k, a[15:7]);
  endfunction

  always @(posedge clk) begin
    for (int b = 0; b < BANKS; b++)
      if (bank_rd_en[b]) bank_rdata[b*WORD_W +: WORD_W] <= bank_val(b, bank_row[b*ROW_W +: ROW_W]);
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  logic [15:0] stim_addr [LANES];
  bit saw_full;

  task automatic push_req(input logic [31:0] m);
    req_mask = m;
    for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = stim_addr[i];
    req_valid = 1'b1;
    while (!req_ready) begin saw_full = 1'b1; step(); end
    step();
    req_valid = 1'b0;
  endtask

  int n_reads, last_read, rsp_at, err_at, max_banks, bank_total;
  logic [BANKS-1:0] rec_en [64];
  logic [BANKS*ROW_W-1:0] rec_row [64];
  logic [LANES*4*WORD_W-1:0] cap_data;
  logic [LANES-1:0] cap_mask;

  task automatic observe(input int span);
    n_reads = 0; last_read = -1; rsp_at = -1; err_at = -1; max_banks = 0; bank_total = 0;
    for (int n = 0; n < span; n++) begin
      if (bank_rd_en != '0) begin
        if (n_reads < 64) begin rec_en[n_reads] = bank_rd_en; rec_row[n_reads] = bank_row; end
        n_reads++;
        last_read = n;
        bank_total += $countones(bank_rd_en);
        if ($countones(bank_rd_en) > max_banks) max_banks = $countones(bank_rd_en);
      end
      if (rsp_valid && rsp_at < 0) begin rsp_at = n; cap_data = rsp_data; cap_mask = rsp_mask; end
      if (err_valid && err_at < 0) err_at = n;
      step();
    end
  endtask

  task automatic check_data(input logic [31:0] m, input string tag);
    int bad = 0;
    longint act_v = 0, exp_v = 0;
    for (int i = 0; i < LANES; i++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] e, a;
        e = m[i] ? exp_word(stim_addr[i], k) : 32'd0;
        a = cap_data[(i*4+k)*WORD_W +: WORD_W];
        if (a !== e) begin
          if (bad == 0) begin act_v = a; exp_v = e; end
          bad++;
        end
      end
    chk(bad == 0, tag, "lane result words", act_v, exp_v);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid === 1'b0 && err_valid === 1'b0, "R1", "rsp/err after reset", {rsp_valid, err_valid}, 0);
    chk(bank_rd_en === '0, "R1", "read enables after reset", bank_rd_en, 0);
  endtask

  task automatic t_full_conflict();
    for (int i = 0; i < LANES; i++) stim_addr[i] = 16'((i + 1) << 7);
    push_req(32'hFFFF_FFFF);
    observe(45);
    chk(n_reads == 32, "R4", "read cycles, 32 distinct in one group", n_reads, 32);
    chk(rsp_at == 35, "R8", "response cycle after accept", rsp_at, 35);
    chk(rsp_at - last_read == 2, "R8", "response gap after last read", rsp_at - last_read, 2);
    chk(max_banks == 4, "R4", "banks per cycle", max_banks, 4);
    check_data(32'hFFFF_FFFF, "R2");
  endtask

  task automatic t_rotation();
    int bad = 0;
    for (int i = 0; i < LANES; i++) stim_addr[i] = 16'h0;
    for (int i = 0; i < 5; i++) stim_addr[i] = 16'((10 + i) << 7);
    push_req(32'h1F);
    observe(20);
    chk(n_reads == 8, "R4", "read cycles for 5 distinct (two windows)", n_reads, 8);
    for (int c = 0; c < 4; c++) begin
      if (rec_en[c] !== 32'hF) bad++;
      for (int b = 0; b < 4; b++)
        if (rec_row[c][b*ROW_W +: ROW_W] !== 9'(10 + ((b - c) & 3))) bad++;
      if (rec_en[4 + c] !== (32'h1 << c)) bad++;
      if (rec_row[4 + c][c*ROW_W +: ROW_W] !== 9'd14) bad++;
    end
    chk(bad == 0, "R3", "rotated word order per window cycle", bad, 0);
    check_data(32'h1F, "R3");
  endtask

  task automatic t_parallel();
    for (int i = 0; i < LANES; i++) stim_addr[i] = 16'(((20 + i / 8) << 7) | ((i % 8) << 4));
    push_req(32'hFFFF_FFFF);
    observe(15);
    chk(n_reads == 4, "R5", "read cycles with all groups busy", n_reads, 4);
    chk(bank_total == 128, "R5", "bank reads, all 32 banks each cycle", bank_total, 128);
    chk(rsp_at == 7, "R8", "response cycle, one window", rsp_at, 7);
    check_data(32'hFFFF_FFFF, "R5");
  endtask

  task automatic t_broadcast();
    for (int i = 0; i < LANES; i++) stim_addr[i] = 16'((3 << 7) | (5 << 4));
    push_req(32'hFFFF_FFFF);
    observe(15);
    chk(n_reads == 4 && bank_total == 4, "R6", "broadcast bank reads", bank_total, 4);
    check_data(32'hFFFF_FFFF, "R6");
  endtask

  task automatic t_mask();
    logic [31:0] m = 32'h0000_F0F0;
    for (int i = 0; i < LANES; i++) stim_addr[i] = m[i] ? 16'(((40 + i) << 7) | (2 << 4)) : 16'h0001;
    push_req(m);
    observe(20);
    chk(err_at < 0, "R7", "inactive misaligned lanes ignored", err_at, -1);
    chk(cap_mask == m, "R7", "rsp_mask echo", cap_mask, m);
    chk(n_reads == 8 && rsp_at == 11, "R7", "response cycle for 8 active distinct", rsp_at, 11);
    check_data(m, "R7");
  endtask

  task automatic t_misalign();
    for (int i = 0; i < LANES; i++) stim_addr[i] = 16'h0;
    stim_addr[0] = 16'h0088;
    push_req(32'h1);
    observe(12);
    chk(err_at == 2, "R11", "error pulse cycle", err_at, 2);
    chk(n_reads == 0 && rsp_at < 0, "R11", "no reads or response", n_reads, 0);
  endtask

  function automatic logic [15:0] q_addr(input int r, input int i);
    return 16'((r * 32 + i + 1) << 7);
  endfunction

  task automatic t_queue();
    int got = 0;
    saw_full = 1'b0;
    fork
      begin
        for (int r = 0; r < 6; r++) begin
          for (int i = 0; i < LANES; i++) stim_addr[i] = q_addr(r, i);
          push_req(~(32'h1 << r));
        end
      end
      begin
        for (int r = 0; r < 6; r++) begin
          int bad = 0, guard = 0;
          while (!rsp_valid && guard < 200) begin step(); guard++; end
          chk(rsp_mask == ~(32'h1 << r), "R9", "response order by mask", rsp_mask, ~(32'h1 << r));
          for (int i = 0; i < LANES; i++)
            for (int k = 0; k < 4; k++) begin
              logic [31:0] e;
              e = (i == r) ? 32'd0 : exp_word(q_addr(r, i), k);
              if (rsp_data[(i*4+k)*WORD_W +: WORD_W] !== e) bad++;
            end
          chk(bad == 0, "R9", "queued transaction data", bad, 0);
          if (rsp_valid) got++;
          step();
        end
      end
    join
    chk(saw_full, "R10", "req_ready dropped with 4 queued", saw_full, 1);
    chk(got == 6, "R10", "all queued requests served", got, 6);
  endtask

  initial begin
    #(50000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) stim_addr[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_full_conflict();
    t_rotation();
    t_parallel();
    t_broadcast();
    t_mask();
    t_misalign();
    t_queue();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule